// File: doc/BRIEF.md
# Pointer-Redirected Byte Store with Table Fetch

This block is the data memory of a small 8-bit accumulator core. The instruction sequencer reaches it through one byte port with a 7-bit address. Each request is one of a small set of operations: read, write, bit set, bit clear or table fetch. The store holds four things: a 32-byte scratch RAM, an 8-bit pointer register, an 8-bit table-index register and a 6-bit port register. Address 00h holds no data. Any request aimed there is steered to the location named by the low seven bits of the pointer.

A table fetch reads one 14-bit program word from the top 256-word page of a 1K-word program store. The table-index register selects the word within that page. The low eight bits of the word go to the addressed byte. The upper six bits land in a dedicated output register. The program store sits outside the block and is synchronous: it returns a word one cycle after it sees the enable. For that reason a fetch takes two cycles, and the block shows `busy` during the second one.

Top module: `ram_ptr_unit`

## Requirements
- R1: After reset, `rdData`, `rdValid`, `tblHigh` and `busy` are 0, and every implemented location reads as 00h.
- R2: Op codes on `reqOp` are: 0 idle, 1 read, 2 write, 3 bit set, 4 bit clear, 5 table fetch, 6 and 7 idle. A read returns its byte on `rdData` with `rdValid` high one cycle after the request. A write takes effect at the request's clock edge. The scratch RAM spans 40h to 5Fh.
- R3: A request of any op to address 00h acts on the location given by bits 6:0 of the pointer. The pointer lives at 01h. The table-index register lives at 07h.
- R4: When bits 6:0 of the pointer are zero, a request to 00h reads 00h, and its write is discarded.
- R5: Bit set forces the byte bit selected by `bitSel` (0 = LSB) to 1. Bit clear forces that bit to 0. All other bits of the byte are unchanged.
- R6: In a table fetch request cycle, `romEn` is high and `romAddr` equals {2'b11, table index}. In the following cycle, `busy` is high and the fetched word is written: bits 7:0 go to the requested byte and bits 13:8 go to `tblHigh`. `tblHigh` changes only at that write.
- R7: The port register sits at 12h. Its bits 7:6 always read 0, whatever was written.
- R8: Any address that maps to no implemented location reads 00h, and a write there changes no location.
- R9: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqOp | input | 3 | Operation code |
| reqAddr | input | 7 | Byte address |
| wrData | input | 8 | Write data |
| bitSel | input | 3 | Bit index for set/clear |
| romData | input | 14 | Program word returned one cycle after `romEn` |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | `rdData` carries a fresh read |
| tblHigh | output | 6 | Upper bits of the last fetched word |
| busy | output | 1 | Second cycle of a table fetch |
| romEn | output | 1 | Program word request |
| romAddr | output | 10 | Program word address |

## Verification
A corrupted pointer first shows up at the very next read through 00h. That read returns the byte of some other location, one cycle after it is requested. A lost or stale fetch target shows up in a different way: the wrong byte changes, and the damage is visible on the first later read of either byte. A wrongly held `busy` or fetch state swallows the request that follows it. That request's effect is then missing from the next read.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_BSET  = 3'd3,
    OP_BCLR  = 3'd4,
    OP_TBLRD = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SRC_BUS = 2'd0,
    SRC_SET = 2'd1,
    SRC_CLR = 2'd2,
    SRC_ROM = 2'd3
  } src_e;

  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    src_e              src;
    logic [BIT_W-1:0]  bitIdx;
    logic              tblhLoad;
    logic [ADDR_W-1:0] effAddr;
  } strobe_t;
endpackage

// File: rtl/ram_ptr_ctrl.sv
module ram_ptr_ctrl
  import ram_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [ADDR_W-1:0] ptrAddr,
  output strobe_t           strb,
  output logic              busy,
  output logic              romEn
);
  logic              pendTbl;
  logic [ADDR_W-1:0] pendAddr;
  logic [ADDR_W-1:0] effNow;

  assign effNow = (reqAddr == '0) ? ptrAddr : reqAddr;
  assign busy   = pendTbl;

  always_comb begin
    strb  = '0;
    romEn = 1'b0;
    if (pendTbl) begin
      strb.wrEn     = 1'b1;
      strb.src      = SRC_ROM;
      strb.tblhLoad = 1'b1;
      strb.effAddr  = pendAddr;
    end else begin
      strb.effAddr = effNow;
      strb.bitIdx  = bitSel;
      case (op_e'(reqOp))
        OP_READ:  strb.rdEn = 1'b1;
        OP_WRITE: begin strb.wrEn = 1'b1; strb.src = SRC_BUS; end
        OP_BSET:  begin strb.wrEn = 1'b1; strb.src = SRC_SET; end
        OP_BCLR:  begin strb.wrEn = 1'b1; strb.src = SRC_CLR; end
        OP_TBLRD: romEn = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTbl  <= 1'b0;
      pendAddr <= '0;
    end else begin
      pendTbl <= romEn;
      if (romEn) pendAddr <= effNow;
    end
  end
endmodule

// File: rtl/ram_ptr_dp.sv
module ram_ptr_dp
  import ram_ptr_pkg::*;
#(
  parameter int RAM_DEPTH = 32,
  parameter int RAM_BASE  = 'h40,
  parameter int PTR_ADDR  = 'h01,
  parameter int TBLP_ADDR = 'h07,
  parameter int PORT_ADDR = 'h12,
  parameter int PORT_BITS = 6,
  parameter int ROM_W     = 14,
  parameter int ROM_AW    = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ROM_W-1:0]         romData,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid,
  output logic [ROM_W-DATA_W-1:0]  tblHigh,
  output logic [ROM_AW-1:0]        romAddr,
  output logic [ADDR_W-1:0]        ptrAddr
);
  localparam int HIGH_W = ROM_W - DATA_W;
  localparam int PAGE_W = ROM_AW - DATA_W;
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [DATA_W-1:0]    ptrReg, tblpReg;
  logic [PORT_BITS-1:0] portReg;
  logic [DATA_W-1:0]    ramMem [RAM_DEPTH];
  logic [DATA_W-1:0]    curByte, nextByte, bitMask;
  logic [ADDR_W-1:0]    ramOff;
  logic [RAM_AW-1:0]    ramIdx;
  logic hitPtr, hitTblp, hitPort, hitRam;

  assign hitPtr  = strb.effAddr == ADDR_W'(PTR_ADDR);
  assign hitTblp = strb.effAddr == ADDR_W'(TBLP_ADDR);
  assign hitPort = strb.effAddr == ADDR_W'(PORT_ADDR);
  assign hitRam  = (int'(strb.effAddr) >= RAM_BASE) &&
                   (int'(strb.effAddr) <  RAM_BASE + RAM_DEPTH);
  assign ramOff  = strb.effAddr - ADDR_W'(RAM_BASE);
  assign ramIdx  = ramOff[RAM_AW-1:0];

  assign ptrAddr = ptrReg[ADDR_W-1:0];
  assign romAddr = {{PAGE_W{1'b1}}, tblpReg};
  assign bitMask = DATA_W'(1) << strb.bitIdx;

  always_comb begin
    if (hitPtr)       curByte = ptrReg;
    else if (hitTblp) curByte = tblpReg;
    else if (hitPort) curByte = DATA_W'(portReg);
    else if (hitRam)  curByte = ramMem[ramIdx];
    else              curByte = '0;
  end

  always_comb begin
    case (strb.src)
      SRC_SET: nextByte = curByte | bitMask;
      SRC_CLR: nextByte = curByte & ~bitMask;
      SRC_ROM: nextByte = romData[DATA_W-1:0];
      default: nextByte = wrData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg  <= '0;
      tblpReg <= '0;
      portReg <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ramMem[i] <= '0;
    end else if (strb.wrEn) begin
      if (hitPtr)  ptrReg  <= nextByte;
      if (hitTblp) tblpReg <= nextByte;
      if (hitPort) portReg <= nextByte[PORT_BITS-1:0];
      if (hitRam)  ramMem[ramIdx] <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      tblHigh <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= curByte;
      if (strb.tblhLoad) tblHigh <= romData[ROM_W-1:ROM_W-HIGH_W];
    end
  end
endmodule

// File: rtl/ram_ptr_unit.sv
module ram_ptr_unit
  import ram_ptr_pkg::*;
#(
  parameter int RAM_DEPTH = 32,
  parameter int RAM_BASE  = 'h40,
  parameter int PTR_ADDR  = 'h01,
  parameter int TBLP_ADDR = 'h07,
  parameter int PORT_ADDR = 'h12,
  parameter int PORT_BITS = 6,
  parameter int ROM_W     = 14,
  parameter int ROM_AW    = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              reqOp,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [BIT_W-1:0]        bitSel,
  input  logic [ROM_W-1:0]        romData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdValid,
  output logic [ROM_W-DATA_W-1:0] tblHigh,
  output logic                    busy,
  output logic                    romEn,
  output logic [ROM_AW-1:0]       romAddr
);
  strobe_t           strb;
  logic [ADDR_W-1:0] ptrAddr;

  ram_ptr_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr),
    .bitSel(bitSel), .ptrAddr(ptrAddr), .strb(strb), .busy(busy),
    .romEn(romEn)
  );

  ram_ptr_dp #(
    .RAM_DEPTH(RAM_DEPTH), .RAM_BASE(RAM_BASE), .PTR_ADDR(PTR_ADDR),
    .TBLP_ADDR(TBLP_ADDR), .PORT_ADDR(PORT_ADDR), .PORT_BITS(PORT_BITS),
    .ROM_W(ROM_W), .ROM_AW(ROM_AW)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .romData(romData), .rdData(rdData), .rdValid(rdValid),
    .tblHigh(tblHigh), .romAddr(romAddr), .ptrAddr(ptrAddr)
  );
endmodule

// File: rtl/ram_ptr_chk.sv
module ram_ptr_chk
  import ram_ptr_pkg::*;
#(
  parameter int PORT_ADDR = 'h12,
  parameter int ROM_W     = 14,
  parameter int ROM_AW    = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2:0]              reqOp,
  input strobe_t                 strb,
  input logic [DATA_W-1:0]       rdData,
  input logic                    rdValid,
  input logic [ROM_W-DATA_W-1:0] tblHigh,
  input logic                    busy,
  input logic                    romEn,
  input logic [ROM_AW-1:0]       romAddr
);
  AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqOp == 3'd1 && !busy)); // R2
  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.effAddr == '0) |=> (rdData == '0)); // R4
  AST_PORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.effAddr == ADDR_W'(PORT_ADDR)) |=> (rdData[7:6] == 2'b00)); // R7
  AST_ROM_LAST_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    romEn |-> (&romAddr[ROM_AW-1:DATA_W])); // R6
  AST_TBL_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    romEn |=> busy); // R6
  AST_TBLH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(tblHigh)); // R6
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R9
  AST_BUSY_NO_ROM: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !romEn); // R9
endmodule

bind ram_ptr_unit ram_ptr_chk #(
  .PORT_ADDR(PORT_ADDR), .ROM_W(ROM_W), .ROM_AW(ROM_AW)
) chk (
  .clk(clk), .rstN(rstN), .reqOp(reqOp), .strb(strb), .rdData(rdData),
  .rdValid(rdValid), .tblHigh(tblHigh), .busy(busy), .romEn(romEn),
  .romAddr(romAddr)
);

// File: tb/ram_ptr_unit_test.sv
`timescale 1ns/1ps
module ram_ptr_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [6:0]  reqAddr = '0;
  logic [7:0]  wrData = '0;
  logic [2:0]  bitSel = '0;
  logic [13:0] romData = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [5:0]  tblHigh;
  logic        busy;
  logic        romEn;
  logic [9:0]  romAddr;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  logic [7:0] mPtr, mTblp;
  logic [5:0] mPort;
  logic [7:0] mRam [32];

  always #2.5 clk = ~clk;

  ram_ptr_unit uut (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr),
    .wrData(wrData), .bitSel(bitSel), .romData(romData), .rdData(rdData),
    .rdValid(rdValid), .tblHigh(tblHigh), .busy(busy), .romEn(romEn),
    .romAddr(romAddr)
  );

  function automatic logic [13:0] romWord(logic [9:0] a);
    return 14'((32'(a) * 32'd173 + 32'd91) ^ 32'h2A5B);
  endfunction

  always @(posedge clk) if (romEn) romData <= romWord(romAddr);

  function automatic logic [6:0] effOf(logic [6:0] a);
    return (a == 7'h00) ? mPtr[6:0] : a;
  endfunction

  function automatic logic [7:0] mRead(logic [6:0] e);
    if (e == 7'h01) return mPtr;
    if (e == 7'h07) return mTblp;
    if (e == 7'h12) return {2'b00, mPort};
    if (e >= 7'h40 && e <= 7'h5F) return mRam[e - 7'h40];
    return 8'h00;
  endfunction

  task automatic mWrite(logic [6:0] e, logic [7:0] v);
    if (e == 7'h01) mPtr = v;
    else if (e == 7'h07) mTblp = v;
    else if (e == 7'h12) mPort = v[5:0];
    else if (e >= 7'h40 && e <= 7'h5F) mRam[e - 7'h40] = v;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic doRead(logic [6:0] a, string req);
    logic [7:0] exp = mRead(effOf(a));
    reqOp = 3'd1; reqAddr = a;
    @(negedge clk);
    reqOp = 3'd0;
    check({req, " rdValid"}, 32'(rdValid), 32'd1);
    check(req, 32'(rdData), 32'(exp));
  endtask

  task automatic doWrite(logic [6:0] a, logic [7:0] d);
    logic [6:0] e = effOf(a);
    reqOp = 3'd2; reqAddr = a; wrData = d;
    @(negedge clk);
    reqOp = 3'd0;
    mWrite(e, d);
  endtask

  task automatic doBit(bit setIt, logic [6:0] a, logic [2:0] b);
    logic [6:0] e = effOf(a);
    logic [7:0] v = mRead(e);
    v = setIt ? (v | (8'h01 << b)) : (v & ~(8'h01 << b));
    reqOp = setIt ? 3'd3 : 3'd4; reqAddr = a; bitSel = b;
    @(negedge clk);
    reqOp = 3'd0;
    mWrite(e, v);
  endtask

  task automatic doTbl(logic [6:0] a, bit intrude);
    logic [6:0]  e = effOf(a);
    logic [13:0] w = romWord({2'b11, mTblp});
    reqOp = 3'd5; reqAddr = a;
    #1;
    check("R6 romEn", 32'(romEn), 32'd1);
    check("R6 romAddr", 32'(romAddr), 32'({2'b11, mTblp}));
    @(negedge clk);
    check("R6 busy", 32'(busy), 32'd1);
    if (intrude) begin
      reqOp = 3'd2; reqAddr = 7'h40; wrData = ~mRam[0];
    end else reqOp = 3'd0;
    @(negedge clk);
    reqOp = 3'd0;
    check("R6 tblHigh", 32'(tblHigh), 32'(w[13:8]));
    check("R9 busy clear", 32'(busy), 32'd0);
    mWrite(e, w[7:0]);
  endtask

  function automatic logic [6:0] pickAddr();
    int r = int'($urandom_range(0, 9));
    case (r)
      0, 1:    return 7'h00;
      2:       return 7'h01;
      3:       return 7'h07;
      4:       return 7'h12;
      5:       return 7'($urandom_range(0, 127));
      default: return 7'(7'h40 + $urandom_range(0, 31));
    endcase
  endfunction

  function automatic logic [7:0] pickData(logic [6:0] a);
    if (a == 7'h01 && $urandom_range(0, 3) != 0) begin
      case ($urandom_range(0, 5))
        0: return 8'h00;
        1: return 8'h80;
        2: return 8'h12;
        3: return 8'h07;
        default: return 8'(8'h40 + $urandom_range(0, 31));
      endcase
    end
    return 8'($urandom);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    mPtr = '0; mTblp = '0; mPort = '0;
    for (int i = 0; i < 32; i++) mRam[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rdData", 32'(rdData), 32'd0);
    check("R1 rdValid", 32'(rdValid), 32'd0);
    check("R1 tblHigh", 32'(tblHigh), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    doRead(7'h5F, "R1 ram");
    doRead(7'h12, "R1 port");
    doRead(7'h01, "R1 ptr");

    // R2: direct write/read and idle codes
    doWrite(7'h40, 8'hA5);
    doRead(7'h40, "R2 ram lo");
    doWrite(7'h5F, 8'h3C);
    doRead(7'h5F, "R2 ram hi");
    reqOp = 3'd6; reqAddr = 7'h40; @(negedge clk);
    check("R2 idle rdValid", 32'(rdValid), 32'd0);
    reqOp = 3'd0;

    // R3: indirect access through pointer
    doWrite(7'h01, 8'h45);
    doWrite(7'h00, 8'h69);
    doRead(7'h45, "R3 indirect write");
    doRead(7'h00, "R3 indirect read");
    doWrite(7'h01, 8'h01);
    doWrite(7'h00, 8'h50);
    doRead(7'h01, "R3 pointer via itself");

    // R4: null pointer
    doWrite(7'h01, 8'h80);
    doWrite(7'h00, 8'hEE);
    doRead(7'h00, "R4 null read");
    doRead(7'h01, "R4 ptr unchanged");
    doRead(7'h40, "R4 ram unchanged");

    // R5: bit operations
    doWrite(7'h41, 8'h00);
    doBit(1'b1, 7'h41, 3'd7);
    doBit(1'b1, 7'h41, 3'd0);
    doRead(7'h41, "R5 set");
    doBit(1'b0, 7'h41, 3'd7);
    doRead(7'h41, "R5 clear");

    // R7: port register masking
    doWrite(7'h12, 8'hFF);
    doRead(7'h12, "R7 port");
    doBit(1'b1, 7'h12, 3'd6);
    doRead(7'h12, "R7 port bit6");

    // R8: unimplemented addresses
    doWrite(7'h30, 8'h55);
    doRead(7'h30, "R8 hole");
    doWrite(7'h7F, 8'h55);
    doRead(7'h7F, "R8 top");

    // R6 and R9: table fetch, and a request swallowed while busy
    doWrite(7'h07, 8'h10);
    doTbl(7'h50, 1'b0);
    doRead(7'h50, "R6 low byte");
    doWrite(7'h01, 8'h52);
    doTbl(7'h00, 1'b1);
    doRead(7'h52, "R6 indirect target");
    doRead(7'h40, "R9 ignored write");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [6:0] a = pickAddr();
      case ($urandom_range(0, 9))
        0, 1, 2: doRead(a, "R2/R3 random read");
        3, 4:    doWrite(a, pickData(a));
        5:       doBit(1'b1, a, 3'($urandom_range(0, 7)));
        6:       doBit(1'b0, a, 3'($urandom_range(0, 7)));
        7:       doTbl(a, bit'($urandom_range(0, 1)));
        default: doRead(a, "R4/R8 random read");
      endcase
    end
    for (int i = 0; i < 32; i++) doRead(7'(7'h40 + i), "R5/R6 final sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule